// File: doc/BRIEF.md
# Burst-Aware Bus Arbiter

This block decides which of several bus masters owns a pipelined, two-phase (address then data) system bus. Each master raises a request line. The arbiter returns a one-hot grant vector and the number of the master that currently drives the address bus. It watches the transfer type, the burst encoding and the system-wide ready signal of the transfer in flight. From these it knows when the owner's burst is nearly finished, and it moves the grant only at that point.

For a burst of known length, the arbiter loads a beat count when the first beat is accepted. The count falls with every accepted beat, and the grant stays with the owner until the final beat has been accepted, whatever the request lines do in the meantime. Cycles with ready low and idle-in-burst cycles do not count, so each one delays the handover by a cycle. For a burst of unknown length, the owner keeps the bus for as long as it keeps requesting. Between bursts, the requesting master with the lowest index wins. If no master is requesting, master 0 gets the bus by default. The master-number output follows the grant at the next edge with ready high, so it lines up with the new owner's first address phase.

Top module: `burst_arbiter`

## Requirements
- R1: After reset, the grant points at master 0 (grant_o = 0001) and owner_o is 0.
- R2: When no burst holds the bus, the lowest-numbered requesting master receives the grant one edge later. With no request, master 0 receives it.
- R3: The grant is always one-hot, with bit i meaning master i.
- R4: owner_o changes only at an edge with ready_i high. At such an edge it takes the index of the master that held the grant before the edge, unless the arbiter is holding the bus for the current owner. While ready_i is low, owner_o stays fixed.
- R5: A burst of known length is detected when a first beat (trans_i = 2'b10) is accepted with burst_i = 3'b010/011 (4 beats), 3'b100/101 (8 beats) or 3'b110/111 (16 beats). The grant then stays on the owner until the final beat is accepted, even if the owner drops its request. At the edge that accepts the final beat, the grant moves to the winner of R2.
- R6: Only edges with ready_i high and trans_i equal to 2'b10 or 2'b11 count as beats. A cycle with ready_i low, or with trans_i = 2'b01 (busy), postpones the handover by exactly one edge.
- R7: In a burst of unknown length (burst_i = 3'b001, trans_i not 2'b00), the grant stays on the owner while that owner's request is high. At the first edge where the request is seen low, the grant moves to the winner of R2.
- R8: A single transfer (burst_i = 3'b000) gives no hold. The grant may move at the same edge that accepts its only beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | N_MASTERS | Request line of each master |
| burst_i | input | 3 | Burst encoding of the transfer on the bus |
| trans_i | input | 2 | Transfer type: 00 idle, 01 busy, 10 first beat, 11 following beat |
| ready_i | input | 1 | System-wide ready; low extends the current data phase |
| grant_o | output | N_MASTERS | One-hot bus grant |
| owner_o | output | IDW | Index of the master driving the address phase |

## Verification
The handover at the end of a burst can fall in the same cycle as a wait state on the final beat. While that happens, a lower-numbered competitor is requesting and the owner has already dropped its request. The bench builds this case by pulling ready low on the last beat of a four-beat burst. It expects the grant to stay on the owner through the stalled edge and to move only at the following ready-high edge, with owner_o trailing by one more edge. A second collision arises when an idle-in-burst cycle lands inside a sixteen-beat wrapping burst. There the release edge must slip by exactly one cycle.

// File: rtl/burst_arbiter.sv
module burst_arbiter #(
  parameter int N_MASTERS = 4,
  localparam int IDW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1,
  localparam int LONGEST = 16,
  localparam int CW = $clog2(LONGEST)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req_i,
  input  logic [2:0]           burst_i,
  input  logic [1:0]           trans_i,
  input  logic                 ready_i,
  output logic [N_MASTERS-1:0] grant_o,
  output logic [IDW-1:0]       owner_o
);

  localparam logic [1:0] T_IDLE   = 2'b00;
  localparam logic [1:0] T_FIRST  = 2'b10;
  localparam logic [2:0] B_UNDEF  = 3'b001;

  logic [CW-1:0]  cnt, cnt_n;
  logic [IDW-1:0] gidx, pick;
  logic           adv, hold_fix, hold_inc, hold;

  function automatic logic [CW-1:0] rest_of(input logic [2:0] b);
    case (b[2:1])
      2'b01:   return CW'(3);
      2'b10:   return CW'(7);
      2'b11:   return CW'(LONGEST - 1);
      default: return '0;
    endcase
  endfunction

  assign adv = ready_i && trans_i[1];

  always_comb begin
    cnt_n = cnt;
    if (ready_i && trans_i == T_IDLE)   cnt_n = '0;
    else if (adv && trans_i == T_FIRST) cnt_n = rest_of(burst_i);
    else if (adv && cnt != '0)          cnt_n = cnt - CW'(1);
  end

  assign hold_fix = (cnt_n != '0);
  assign hold_inc = (burst_i == B_UNDEF) && (trans_i != T_IDLE) && req_i[owner_o];
  assign hold     = hold_fix || hold_inc;

  always_comb begin
    pick = '0;
    for (int i = N_MASTERS - 1; i >= 0; i--)
      if (req_i[i]) pick = IDW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      gidx    <= '0;
      owner_o <= '0;
    end else begin
      cnt  <= cnt_n;
      gidx <= hold ? owner_o : pick;
      if (ready_i && !hold) owner_o <= gidx;
    end
  end

  for (genvar g = 0; g < N_MASTERS; g++) begin : g_dec
    assign grant_o[g] = (gidx == IDW'(g));
  end

endmodule

// File: rtl/burst_arbiter_chk.sv
module burst_arbiter_chk #(
  parameter int N_MASTERS = 4,
  parameter int IDW = 2,
  parameter int CW = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_MASTERS-1:0] req_i,
  input logic [2:0]           burst_i,
  input logic [1:0]           trans_i,
  input logic                 ready_i,
  input logic [N_MASTERS-1:0] grant_o,
  input logic [IDW-1:0]       owner_o,
  input logic [CW-1:0]        cnt
);

  // R4
  owner_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_i |=> $stable(owner_o));

  // R3
  grant_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant_o) == 1);

  // R5
  beat_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_i && trans_i == 2'b11 && cnt > CW'(1)) |=> $stable(grant_o));

  // R6
  wait_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_i && cnt != '0) |=> $stable(grant_o));

  // R7
  undef_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_i == 3'b001 && trans_i != 2'b00 && req_i[owner_o]) |=> grant_o[$past(owner_o)]);

  // R2
  idle_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && req_i == '0 && trans_i == 2'b00) |=> grant_o[0]);

endmodule

bind burst_arbiter burst_arbiter_chk #(.N_MASTERS(N_MASTERS), .IDW(IDW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .burst_i(burst_i), .trans_i(trans_i),
  .ready_i(ready_i), .grant_o(grant_o), .owner_o(owner_o), .cnt(cnt)
);

// File: tb/test_burst_arbiter.sv
`timescale 1ns/1ps
module test_burst_arbiter;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] req = '0;
  logic [2:0] burst = '0;
  logic [1:0] trans = '0;
  logic       ready = 1;
  logic [3:0] grant;
  logic [1:0] owner;
  int total = 0, bad = 0;

  localparam logic [1:0] IDLE = 2'b00, BUSY = 2'b01, FIRST = 2'b10, NEXT = 2'b11;

  always #2 clk = ~clk;

  burst_arbiter #(.N_MASTERS(4)) i_burst_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req), .burst_i(burst), .trans_i(trans),
    .ready_i(ready), .grant_o(grant), .owner_o(owner)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string r, input logic [3:0] eg, input int eo);
    total++;
    if (grant !== eg || owner !== 2'(eo)) begin
      bad++;
      $display("FAIL %s: grant=%b owner=%0d expected grant=%b owner=%0d", r, grant, owner, eg, eo);
    end
  endtask

  task automatic t_reset();
    #1; chk("R1 reset", 4'b0001, 0);
    rst_n = 1; tick();
    chk("R1 after release", 4'b0001, 0);
  endtask

  task automatic t_priority();
    req = 4'b1010; trans = IDLE; tick();
    chk("R2 lowest wins", 4'b0010, 0);
    tick(); chk("R4 owner follows", 4'b0010, 1);
    req = 4'b1000; tick(); chk("R2 single req", 4'b1000, 1);
    tick(); chk("R4 owner 3", 4'b1000, 3);
    req = 4'b0000; tick(); chk("R2 default master", 4'b0001, 3);
    tick(); chk("R4 owner back", 4'b0001, 0);
  endtask

  task automatic t_fixed4_wait();
    req = 4'b0100; tick(); tick();
    chk("R2 setup M2", 4'b0100, 2);
    trans = FIRST; burst = 3'b011; req = 4'b0010; tick();
    chk("R5 held after first beat", 4'b0100, 2);
    trans = NEXT; tick(); chk("R5 beat2", 4'b0100, 2);
    tick(); chk("R5 beat3", 4'b0100, 2);
    ready = 0; tick(); chk("R6 wait on last beat", 4'b0100, 2);
    ready = 1; tick(); chk("R5 release on last beat", 4'b0010, 2);
    trans = IDLE; tick(); chk("R4 new owner", 4'b0010, 1);
  endtask

  task automatic t_undef();
    req = 4'b0001; tick(); tick();
    chk("R2 setup M0", 4'b0001, 0);
    req = 4'b0011; trans = FIRST; burst = 3'b001; tick();
    chk("R7 held first", 4'b0001, 0);
    trans = NEXT;
    for (int k = 0; k < 5; k++) begin
      tick(); chk("R7 held while requesting", 4'b0001, 0);
    end
    req = 4'b0010; tick(); chk("R7 release on drop", 4'b0010, 0);
    trans = IDLE; tick(); chk("R7 owner moves", 4'b0010, 1);
  endtask

  task automatic t_single();
    req = 4'b0011; trans = FIRST; burst = 3'b000; tick();
    chk("R8 no hold", 4'b0001, 1);
    trans = IDLE; tick(); chk("R8 owner moves", 4'b0001, 0);
  endtask

  task automatic t_ready_low();
    req = 4'b0100; ready = 0; tick();
    chk("R4 grant moves, owner waits", 4'b0100, 0);
    tick(); chk("R4 owner still waits", 4'b0100, 0);
    ready = 1; tick(); chk("R4 owner on ready", 4'b0100, 2);
  endtask

  task automatic t_wrap16_busy();
    req = 4'b0011; trans = FIRST; burst = 3'b110; tick();
    chk("R5 wrap16 first", 4'b0100, 2);
    trans = NEXT;
    for (int k = 1; k <= 5; k++) tick();
    trans = BUSY; tick(); chk("R6 busy no count", 4'b0100, 2);
    trans = NEXT;
    for (int k = 6; k <= 14; k++) tick();
    chk("R5 held before last", 4'b0100, 2);
    tick(); chk("R5 wrap16 release", 4'b0001, 2);
    trans = IDLE; tick(); chk("R4 owner after wrap16", 4'b0001, 0);
  endtask

  initial begin
    #100us;
    bad++; total++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_priority();
    t_fixed4_wait();
    t_undef();
    t_single();
    t_ready_low();
    t_wrap16_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule